// File: doc/BRIEF.md
# Address-Triggered Register File

This block holds three banks of eight registers: address registers and index registers of 18 bits, and data registers of 60 bits. Writing an address register can start a memory transfer on its own. A write to address register 1, 2, 3, 4 or 5 sends a read to memory at the new address. The returned word lands in the data register with the same number. A write to address register 6 or 7 sends a store of data register 6 or 7 to the new address. Address register 0, the index registers and the data registers never start memory traffic.

Host writes arrive on a valid/ready port. A write completes on a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` falls when the request queue is full. While it is low the host must hold its write, and that write has no effect. Memory requests leave on a valid/ready port in the order their address writes happened. While `mem_req_valid` is high and `mem_req_ready` is low, the request fields stay unchanged. Read data returns on `mem_rsp_valid`, in the order the reads were issued. The block takes a response on every cycle that `mem_rsp_valid` is high. The read port is combinational. It raises `rd_stall` when it reads a data register that still waits for a memory read.

Top module: `trig_regfile`

## Requirements
- R1: A write with bank select 0 (address), 1 (index) or 2 (data) stores `wr_data` in the register chosen by `wr_idx`. Address and index registers keep the low 18 bits, and data registers keep all 60. The read port returns the selected register, zero-extended, in the same cycle. Bank select 3 ignores writes and reads as zero.
- R2: Index register 0 always reads as zero, and writes to it are ignored.
- R3: Writing address register 0, any index register or any data register issues no memory request.
- R4: Writing address register n, for n from 1 to 5, puts a read request (`mem_req_write`=0, address equal to the written 18 bits) on the memory port from the next cycle when the queue was empty. The response data is written into data register n.
- R5: A data register whose memory read is outstanding reads with `rd_stall`=1. The flag holds from the cycle after the address write until the cycle after the last response for that register.
- R6: Writing address register 6 or 7 issues a store request (`mem_req_write`=1) to the written address. Its `mem_req_wdata` is the value the data register held when the address was written. Later writes to that data register do not change it.
- R7: Memory requests leave in the order of their address writes. The queue holds 4 entries by default.
- R8: If an address register is written again while its earlier read is outstanding, the data register takes the newer read's data last, and `rd_stall` stays high until both responses arrive.
- R9: `wr_ready` is low while the request queue is full, and a write offered then is not taken. A request with `mem_req_valid` high and `mem_req_ready` low keeps all its fields stable on the next cycle.
- R10: Responses are matched to issued reads in issue order. At most 4 reads are outstanding at memory by default.
- R11: After reset all registers read zero, no data register is pending, no request is valid and `wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write offered |
| wr_ready | output | 1 | Host write can be taken |
| wr_sel | input | 2 | Write bank: 0 address, 1 index, 2 data, 3 none |
| wr_idx | input | 3 | Write register number |
| wr_data | input | 60 | Write value |
| rd_sel | input | 2 | Read bank, same coding as `wr_sel` |
| rd_idx | input | 3 | Read register number |
| rd_data | output | 60 | Read value, zero-extended |
| rd_stall | output | 1 | Selected data register awaits memory |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 for a store, 0 for a read |
| mem_req_addr | output | 18 | Request address |
| mem_req_wdata | output | 60 | Store data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 60 | Returned word |

## Verification
A wrong pending count shows at `rd_stall` on the first read of that data register after its response, or after its address write. A lost or reordered entry in the request queue shows at `mem_req_addr` or `mem_req_write` as soon as that entry reaches the head. A misrouted return tag writes a response into the wrong data register, and a readback shows it one cycle after the response. A store that reads its data register late instead of capturing it gives a `mem_req_wdata` that matches the newer value, and the bench sets that up by rewriting the register before the request drains.

// File: rtl/trf_pkg.sv
package trf_pkg;
  typedef enum logic [1:0] {
    BANK_ADDR  = 2'd0,
    BANK_INDEX = 2'd1,
    BANK_DATA  = 2'd2,
    BANK_NONE  = 2'd3
  } bank_e;
endpackage

// File: rtl/trf_fifo.sv
module trf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] pdata,
  input  logic         pop,
  output logic [W-1:0] qdata,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign qdata   = slot[rp];

  always_ff @(posedge clk) begin
    if (do_push) slot[wp] <= pdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/trf_pending.sv
module trf_pending #(
  parameter int NREG = 8,
  parameter int CW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] inc,
  input  logic [NREG-1:0] dec,
  output logic [NREG-1:0] busy
);
  for (genvar g = 0; g < NREG; g++) begin : g_cnt
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else begin
        case ({inc[g], dec[g]})
          2'b10:   cnt_q <= cnt_q + 1'b1;
          2'b01:   cnt_q <= cnt_q - 1'b1;
          default: cnt_q <= cnt_q;
        endcase
      end
    end
    assign busy[g] = (cnt_q != '0);
  end
endmodule

// File: rtl/trf_bank.sv
module trf_bank #(
  parameter int W     = 18,
  parameter int NREG  = 8,
  parameter bit ZERO0 = 1'b0,
  localparam int IW   = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    a_we,
  input  logic [IW-1:0]           a_idx,
  input  logic [W-1:0]            a_d,
  input  logic                    b_we,
  input  logic [IW-1:0]           b_idx,
  input  logic [W-1:0]            b_d,
  output logic [NREG-1:0][W-1:0]  q
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (ZERO0 && g == 0) begin : g_zero
      assign q[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk) begin
        if (!rst_n)                           q[g] <= '0;
        else if (b_we && b_idx == IW'(g))     q[g] <= b_d;
        else if (a_we && a_idx == IW'(g))     q[g] <= a_d;
      end
    end
  end
endmodule

// File: rtl/trig_regfile.sv
module trig_regfile #(
  parameter int AW        = 18,
  parameter int DW        = 60,
  parameter int NREG      = 8,
  parameter int LOAD_LO   = 1,
  parameter int LOAD_HI   = 5,
  parameter int REQ_DEPTH = 4,
  parameter int RET_DEPTH = 4,
  localparam int IW       = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [1:0]    wr_sel,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          rd_stall,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  import trf_pkg::*;

  localparam int EW  = 1 + IW + AW + DW;
  localparam int PCW = $clog2(REQ_DEPTH + RET_DEPTH + 1);

  logic [NREG-1:0][AW-1:0] addr_q, index_q;
  logic [NREG-1:0][DW-1:0] data_q;
  logic [NREG-1:0]         busy, inc_v, dec_v;

  logic          wr_fire, addr_we, index_we, data_we;
  logic          trig_load, trig_store;
  logic          rq_empty, rq_full, rq_pop;
  logic [EW-1:0] rq_in, rq_head;
  logic          head_store;
  logic [IW-1:0] head_idx;
  logic          tq_empty, tq_full, rsp_take;
  logic [IW-1:0] tq_head;

  assign wr_ready = !rq_full;
  assign wr_fire  = wr_valid && wr_ready;
  assign addr_we  = wr_fire && (bank_e'(wr_sel) == BANK_ADDR);
  assign index_we = wr_fire && (bank_e'(wr_sel) == BANK_INDEX);
  assign data_we  = wr_fire && (bank_e'(wr_sel) == BANK_DATA);

  assign trig_load  = addr_we && (wr_idx >= IW'(LOAD_LO)) && (wr_idx <= IW'(LOAD_HI));
  assign trig_store = addr_we && (wr_idx > IW'(LOAD_HI));

  trf_bank #(.W(AW), .NREG(NREG), .ZERO0(1'b0)) u_addr (
    .clk, .rst_n,
    .a_we(addr_we), .a_idx(wr_idx), .a_d(wr_data[AW-1:0]),
    .b_we(1'b0), .b_idx('0), .b_d('0),
    .q(addr_q)
  );

  trf_bank #(.W(AW), .NREG(NREG), .ZERO0(1'b1)) u_index (
    .clk, .rst_n,
    .a_we(index_we), .a_idx(wr_idx), .a_d(wr_data[AW-1:0]),
    .b_we(1'b0), .b_idx('0), .b_d('0),
    .q(index_q)
  );

  trf_bank #(.W(DW), .NREG(NREG), .ZERO0(1'b0)) u_data (
    .clk, .rst_n,
    .a_we(data_we), .a_idx(wr_idx), .a_d(wr_data),
    .b_we(rsp_take), .b_idx(tq_head), .b_d(mem_rsp_data),
    .q(data_q)
  );

  // request entry: {store, register, address, captured store word}
  assign rq_in = {trig_store, wr_idx, wr_data[AW-1:0], data_q[wr_idx]};

  trf_fifo #(.W(EW), .DEPTH(REQ_DEPTH)) u_reqq (
    .clk, .rst_n,
    .push(trig_load || trig_store), .pdata(rq_in),
    .pop(rq_pop), .qdata(rq_head),
    .empty(rq_empty), .full(rq_full)
  );

  assign head_store    = rq_head[EW-1];
  assign head_idx      = rq_head[EW-2 -: IW];
  assign mem_req_addr  = rq_head[DW +: AW];
  assign mem_req_wdata = rq_head[DW-1:0];
  assign mem_req_write = head_store;
  assign mem_req_valid = !rq_empty && (head_store || !tq_full);
  assign rq_pop        = mem_req_valid && mem_req_ready;

  trf_fifo #(.W(IW), .DEPTH(RET_DEPTH)) u_tagq (
    .clk, .rst_n,
    .push(rq_pop && !head_store), .pdata(head_idx),
    .pop(rsp_take), .qdata(tq_head),
    .empty(tq_empty), .full(tq_full)
  );

  assign rsp_take = mem_rsp_valid && !tq_empty;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      inc_v[i] = trig_load && (wr_idx == IW'(i));
      dec_v[i] = rsp_take && (tq_head == IW'(i));
    end
  end

  trf_pending #(.NREG(NREG), .CW(PCW)) u_pend (
    .clk, .rst_n, .inc(inc_v), .dec(dec_v), .busy(busy)
  );

  always_comb begin
    rd_data  = '0;
    rd_stall = 1'b0;
    case (bank_e'(rd_sel))
      BANK_ADDR:  rd_data = DW'(addr_q[rd_idx]);
      BANK_INDEX: rd_data = DW'(index_q[rd_idx]);
      BANK_DATA: begin
        rd_data  = data_q[rd_idx];
        rd_stall = busy[rd_idx];
      end
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/trf_checker.sv
module trf_checker #(
  parameter int AW = 18,
  parameter int DW = 60,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [1:0]    wr_sel,
  input logic [1:0]    rd_sel,
  input logic [IW-1:0] rd_idx,
  input logic [DW-1:0] rd_data,
  input logic          rd_stall,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [AW-1:0] mem_req_addr,
  input logic [DW-1:0] mem_req_wdata,
  input logic          mem_rsp_valid
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr) && $stable(mem_req_wdata)));

  // R2
  idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd1 && rd_idx == '0) |-> (rd_data == '0));

  // R5
  stall_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stall |-> (rd_sel == 2'd2));

  // R3
  no_spurious_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req_valid && !mem_rsp_valid && !(wr_valid && wr_ready && wr_sel == 2'd0)) |=> !mem_req_valid);
endmodule

bind trig_regfile trf_checker #(.AW(AW), .DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_sel(wr_sel),
  .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data), .rd_stall(rd_stall),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/sim_trig_regfile.sv
module sim_trig_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid, wr_ready;
  logic [1:0]  wr_sel, rd_sel;
  logic [2:0]  wr_idx, rd_idx;
  logic [59:0] wr_data, rd_data, mem_req_wdata, mem_rsp_data;
  logic        rd_stall, mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid;
  logic [17:0] mem_req_addr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  trig_regfile u0 (
    .clk, .rst_n, .wr_valid, .wr_ready, .wr_sel, .wr_idx, .wr_data,
    .rd_sel, .rd_idx, .rd_data, .rd_stall,
    .mem_req_valid, .mem_req_ready, .mem_req_write, .mem_req_addr, .mem_req_wdata,
    .mem_rsp_valid, .mem_rsp_data
  );

  // {bank, register, write value, expected readback}
  localparam logic [124:0] VEC [0:9] = '{
    {2'd0, 3'd0, 60'hFFF_FFFF_FFF3_ABCD, 60'h3ABCD},           // R1 R3 address 0
    {2'd0, 3'd0, 60'h0000_0000_0001_2345, 60'h12345},          // R3 address 0 again
    {2'd1, 3'd3, 60'h0000_0000_0001_2345, 60'h12345},          // R1 index
    {2'd1, 3'd7, 60'hFFF_FFFF_FFFF_FFFF, 60'h3FFFF},           // R1 truncation
    {2'd1, 3'd0, 60'h0000_0000_0001_FFFF, 60'h0},              // R2
    {2'd2, 3'd1, 60'hFED_CBA9_8765_4321, 60'hFED_CBA9_8765_4321}, // R1 R3 data
    {2'd2, 3'd6, 60'h0AB_CDEF_0123_4567, 60'h0AB_CDEF_0123_4567},
    {2'd2, 3'd7, 60'h111_2222_3333_4444, 60'h111_2222_3333_4444},
    {2'd2, 3'd0, 60'hFFF_FFFF_FFFF_FFFF, 60'hFFF_FFFF_FFFF_FFFF},
    {2'd3, 3'd2, 60'h555_5555_5555_5555, 60'h0}                // R1 bank 3
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [2:0] idx, logic [59:0] val);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = sel; wr_idx = idx; wr_data = val;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    #1 wr_valid = 1'b0;
  endtask

  task automatic rd(logic [1:0] sel, logic [2:0] idx);
    rd_sel = sel; rd_idx = idx;
    #1;
  endtask

  task automatic take(string req, logic w, logic [17:0] a, logic [59:0] d);
    @(negedge clk);
    check(req, {63'd0, mem_req_valid}, 64'd1);
    check(req, {63'd0, mem_req_write}, {63'd0, w});
    check(req, {46'd0, mem_req_addr}, {46'd0, a});
    if (w) check(req, {4'd0, mem_req_wdata}, {4'd0, d});
    mem_req_ready = 1'b1;
    @(posedge clk);
    #1 mem_req_ready = 1'b0;
  endtask

  task automatic resp(logic [59:0] d);
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_data = d;
    @(posedge clk);
    #1 mem_rsp_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all) actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_sel = '0; wr_idx = '0; wr_data = '0;
    rd_sel = '0; rd_idx = '0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R11 reset state
    #1;
    check("R11", {63'd0, mem_req_valid}, 64'd0);
    check("R11", {63'd0, wr_ready}, 64'd1);
    rd(2'd2, 3'd3);
    check("R11", {4'd0, rd_data}, 64'd0);
    check("R11", {63'd0, rd_stall}, 64'd0);
    rd(2'd0, 3'd5);
    check("R11", {4'd0, rd_data}, 64'd0);

    // table walk: plain writes, readback, no memory traffic
    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][124:123], VEC[i][122:120], VEC[i][119:60]);
      @(negedge clk);
      check("R3", {63'd0, mem_req_valid}, 64'd0);
      rd(VEC[i][124:123], VEC[i][122:120]);
      check("R1/R2", {4'd0, rd_data}, {4'd0, VEC[i][59:0]});
    end

    // R4 R5 single load
    wr(2'd0, 3'd1, 60'h00111);
    rd(2'd2, 3'd1);
    check("R5", {63'd0, rd_stall}, 64'd1);
    take("R4", 1'b0, 18'h00111, '0);
    rd(2'd2, 3'd1);
    check("R5", {63'd0, rd_stall}, 64'd1);
    resp(60'hA5A_5A5A_5A5A_5A5A);
    rd(2'd2, 3'd1);
    check("R5", {63'd0, rd_stall}, 64'd0);
    check("R4", {4'd0, rd_data}, {4'd0, 60'hA5A_5A5A_5A5A_5A5A});

    // R6 store captures data at address write
    wr(2'd2, 3'd6, 60'h123_4567_89AB_CDEF);
    wr(2'd0, 3'd6, 60'h20006);
    wr(2'd2, 3'd6, 60'hBEE_BEEB_EEBE_EBEE);
    take("R6", 1'b1, 18'h20006, 60'h123_4567_89AB_CDEF);
    rd(2'd2, 3'd6);
    check("R6", {4'd0, rd_data}, {4'd0, 60'hBEE_BEEB_EEBE_EBEE});
    check("R6", {63'd0, rd_stall}, 64'd0);
    wr(2'd0, 3'd7, 60'h00070);
    take("R6", 1'b1, 18'h00070, 60'h111_2222_3333_4444);

    // R8 double write to the same address register
    wr(2'd0, 3'd2, 60'h00100);
    wr(2'd0, 3'd2, 60'h00200);
    take("R8", 1'b0, 18'h00100, '0);
    take("R8", 1'b0, 18'h00200, '0);
    resp(60'h000_0000_0000_00D1);
    rd(2'd2, 3'd2);
    check("R8", {63'd0, rd_stall}, 64'd1);
    resp(60'h000_0000_0000_00D2);
    rd(2'd2, 3'd2);
    check("R8", {63'd0, rd_stall}, 64'd0);
    check("R8", {4'd0, rd_data}, 64'hD2);

    // R7 R9 R10 fill the queue, order, back-pressure
    wr(2'd0, 3'd3, 60'h00300);
    wr(2'd0, 3'd6, 60'h00600);
    wr(2'd0, 3'd4, 60'h00400);
    wr(2'd0, 3'd5, 60'h00500);
    check("R9", {63'd0, wr_ready}, 64'd0);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = 2'd1; wr_idx = 3'd5; wr_data = 60'h55;
    @(posedge clk);
    #1 wr_valid = 1'b0;
    rd(2'd1, 3'd5);
    check("R9", {4'd0, rd_data}, 64'd0);
    check("R9", {46'd0, mem_req_addr}, 64'h300);
    take("R7", 1'b0, 18'h00300, '0);
    take("R7", 1'b1, 18'h00600, 60'hBEE_BEEB_EEBE_EBEE);
    take("R7", 1'b0, 18'h00400, '0);
    take("R7", 1'b0, 18'h00500, '0);
    resp(60'h33);
    resp(60'h44);
    resp(60'h55);
    rd(2'd2, 3'd3);
    check("R10", {4'd0, rd_data}, 64'h33);
    rd(2'd2, 3'd4);
    check("R10", {4'd0, rd_data}, 64'h44);
    rd(2'd2, 3'd5);
    check("R10", {4'd0, rd_data}, 64'h55);
    check("R10", {63'd0, rd_stall}, 64'd0);

    finish_run();
  end
endmodule